// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block decides, cycle by cycle, whether a new task may be launched into a statically configured, single-function pipeline whose stages are reused over several cycles. It keeps a collision state derived from the set of forbidden launch distances. A launch is withheld whenever it would place two tasks in one stage in the same cycle. The collision vector has one bit per latency: bit index k-1 is 1 exactly when a launch k cycles after another launch is forbidden. Its most significant bit stands for the largest forbidden latency.

The controller works greedily. A waiting request is granted in the first cycle at which the distance to every earlier launch still in flight is permitted. The grant is combinational from the request and the registered state. The state is shifted right by one every cycle and, on each grant, merged by OR with the collision vector. A variant parameter selects whether the collision vector is a fixed parameter or is taken from a configuration input.

Top module: `initiation_gate`

## Requirements
- R1: After a synchronous reset, and before any grant, `allow` is 1, so the first request is granted in the cycle in which it is presented. The stored state equals the collision vector.
- R2: `grant` is 1 only in a cycle in which `req` is 1, and `grant` equals `req` combined with `allow` in the same cycle, with no register between them.
- R3: No grant is ever issued k cycles after an earlier grant when bit k-1 of the collision vector in force at that earlier grant is 1. For the default vector this means no stage of the served pipeline is ever booked twice in one cycle.
- R4: Greedy issue. While `req` is held, the grant comes in the first cycle whose distance to every in-flight launch is permitted. A request is refused only when such a collision would occur.
- R5: After a grant at latency i, the next state is the previous state shifted right by i, ORed with the collision vector. With the vector 8'b10011101 (forbidden 1,3,4,5,8) and a request held continuously, grants fall at relative cycles 0, 2, 9 and 11: the launch distances alternate 2 and 7.
- R6: A launch more than N_LAT cycles after the previous one is always permitted, and the state then reloads to the collision vector alone.
- R7: With CV_SRC set to take the vector from the port, `cfg_cv` is sampled at reset and at each grant, and it changes the issue pattern of later grants. With CV_SRC set to the parameter, `cfg_cv` has no effect on `allow` or `grant`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | A task is waiting to be launched |
| cfg_cv | input | N_LAT | Collision vector when the port variant is chosen; bit k-1 forbids latency k |
| allow | output | 1 | A launch in this cycle would cause no collision |
| grant | output | 1 | The waiting task is launched in this cycle |

## Verification
The bench builds two copies. The first uses N_LAT = 8 and the parameter vector 8'b10011101, with `cfg_cv` tied to all ones. This brings the reference greedy cycle of distances 2 and 7, idle gaps longer than eight cycles, and proof that the port is ignored within reach. Each of its grants is compared against a four-stage reservation table whose same-stage distances give exactly that forbidden set. The second copy selects the port variant with N_LAT = 8. It is driven first with forbidden set {1,3} and then with {2}, so the reload of the vector at each grant can be observed.

// File: rtl/initiation_gate_pkg.sv
package initiation_gate_pkg;

   typedef enum logic [0:0] {
      CV_FROM_PARAM = 1'b0,
      CV_FROM_PORT  = 1'b1
   } cv_src_e;

   localparam int unsigned MAX_LAT = 64;

endpackage

// File: rtl/initiation_gate_source.sv
module initiation_gate_source
   import initiation_gate_pkg::*;
#(
   parameter int unsigned      N_LAT    = 8,
   parameter cv_src_e          CV_SRC   = CV_FROM_PARAM,
   parameter logic [N_LAT-1:0] CV_PARAM = '1
) (
   input  logic [N_LAT-1:0] cfg_cv,
   output logic [N_LAT-1:0] cv
);

   generate
      if (CV_SRC == CV_FROM_PORT) begin : g_port
         assign cv = cfg_cv;
      end else begin : g_param
         logic cfg_unused;
         assign cfg_unused = ^cfg_cv;
         assign cv         = CV_PARAM;
      end
   endgenerate

endmodule

// File: rtl/initiation_gate_merge.sv
module initiation_gate_merge #(
   parameter int unsigned N_LAT = 8
) (
   input  logic [N_LAT-1:0] cur,
   input  logic             load,
   input  logic [N_LAT-1:0] cv,
   output logic [N_LAT-1:0] nxt
);

   // Per bit: take the neighbour above (one cycle closer), then merge the vector.
   genvar k;
   generate
      for (k = 0; k < N_LAT; k++) begin : g_bit
         if (k == N_LAT - 1) begin : g_top
            assign nxt[k] = load & cv[k];
         end else begin : g_mid
            assign nxt[k] = cur[k+1] | (load & cv[k]);
         end
      end
   endgenerate

endmodule

// File: rtl/initiation_gate_hold.sv
module initiation_gate_hold #(
   parameter int unsigned N_LAT = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_LAT-1:0] cv,
   input  logic [N_LAT-1:0] nxt,
   input  logic             grant,
   output logic [N_LAT-1:0] state,
   output logic             fresh
);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= cv;
         fresh <= 1'b1;
      end else begin
         state <= nxt;
         if (grant) fresh <= 1'b0;
      end
   end

endmodule

// File: rtl/initiation_gate.sv
module initiation_gate
   import initiation_gate_pkg::*;
#(
   parameter int unsigned      N_LAT    = 8,
   parameter cv_src_e          CV_SRC   = CV_FROM_PARAM,
   parameter logic [N_LAT-1:0] CV_PARAM = N_LAT'(8'h9D)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic [N_LAT-1:0] cfg_cv,
   output logic             allow,
   output logic             grant
);

   generate
      if (N_LAT < 1 || N_LAT > MAX_LAT) begin : g_bad_width
         $error("initiation_gate: N_LAT out of range");
      end
      if (CV_SRC == CV_FROM_PARAM && CV_PARAM[N_LAT-1] == 1'b0) begin : g_bad_cv
         $error("initiation_gate: top bit of CV_PARAM must mark the largest forbidden latency");
      end
   endgenerate

   logic [N_LAT-1:0] cv_eff;
   logic [N_LAT-1:0] state;
   logic [N_LAT-1:0] cur;
   logic [N_LAT-1:0] nxt;
   logic             fresh;
   logic             load;

   initiation_gate_source #(
      .N_LAT   (N_LAT),
      .CV_SRC  (CV_SRC),
      .CV_PARAM(CV_PARAM)
   ) u_source (
      .cfg_cv(cfg_cv),
      .cv    (cv_eff)
   );

   // Until the first launch nothing is in flight, so every cycle is open.
   assign allow = fresh | ~state[0];
   assign grant = req & allow;
   assign cur   = fresh ? '0 : state;
   assign load  = grant | fresh;

   initiation_gate_merge #(
      .N_LAT(N_LAT)
   ) u_merge (
      .cur (cur),
      .load(load),
      .cv  (cv_eff),
      .nxt (nxt)
   );

   initiation_gate_hold #(
      .N_LAT(N_LAT)
   ) u_hold (
      .clk  (clk),
      .rst  (rst),
      .cv   (cv_eff),
      .nxt  (nxt),
      .grant(grant),
      .state(state),
      .fresh(fresh)
   );

endmodule

// File: rtl/initiation_gate_chk.sv
module initiation_gate_chk #(
   parameter int unsigned N_LAT = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             req,
   input logic             allow,
   input logic             grant,
   input logic [N_LAT-1:0] cv
);

   localparam int unsigned LW = $clog2(N_LAT + 2);

   // fb[k] holds the vector in force at a grant k+1 cycles ago, or zero.
   logic [N_LAT-1:0] fb [N_LAT];
   logic             clash;
   logic [LW-1:0]    lat_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < N_LAT; k++) fb[k] <= '0;
         lat_q <= LW'(N_LAT + 1);
      end else begin
         fb[0] <= grant ? cv : '0;
         for (int k = 1; k < N_LAT; k++) fb[k] <= fb[k-1];
         if (grant) lat_q <= LW'(1);
         else if (lat_q < LW'(N_LAT + 1)) lat_q <= lat_q + LW'(1);
      end
   end

   always_comb begin
      clash = 1'b0;
      for (int k = 0; k < N_LAT; k++) clash = clash | fb[k][k];
   end

   p_open_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> allow);

   p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
      !req |-> !grant);

   p_no_collision_r3: assert property (@(posedge clk) disable iff (rst)
      grant |-> !clash);

   p_greedy_r4: assert property (@(posedge clk) disable iff (rst)
      (req && !grant) |-> clash);

   p_long_gap_open_r6: assert property (@(posedge clk) disable iff (rst)
      (lat_q > LW'(N_LAT)) |-> allow);

endmodule

bind initiation_gate initiation_gate_chk #(.N_LAT(N_LAT)) u_chk (
   .clk  (clk),
   .rst  (rst),
   .req  (req),
   .allow(allow),
   .grant(grant),
   .cv   (cv_eff)
);

// File: tb/initiation_gate_bench.sv
module initiation_gate_bench;
   import initiation_gate_pkg::*;

   localparam int CLK_PERIOD = 10;

   // Reservation table of the served pipeline, bit j = stage busy j cycles after launch.
   // Same-stage distances: 1 | 4,8 | 3 | 5  -> forbidden set {1,3,4,5,8}.
   localparam logic [8:0] RT [4] = '{9'b000000011, 9'b100010001,
                                     9'b000010010, 9'b010000100};

   // {req, expected grant} per cycle for vector 8'b10011101.
   localparam logic [1:0] VEC [36] = '{
      2'b11, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b10, 2'b11,
      2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
      2'b11, 2'b10, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10, 2'b11};

   logic       clk  = 1'b0;
   logic       rst  = 1'b1;
   logic       req  = 1'b0;
   logic       req2 = 1'b0;
   logic [7:0] cfg_main = 8'hFF;
   logic [7:0] cfg2     = 8'h05;
   logic       allow, grant, allow2, grant2;

   int         nchk  = 0;
   int         nfail = 0;
   logic       done  = 1'b0;
   logic       m_allow;
   logic [8:0] busy [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   initiation_gate #(.N_LAT(8), .CV_SRC(CV_FROM_PARAM), .CV_PARAM(8'b10011101)) u_initiation_gate (
      .clk(clk), .rst(rst), .req(req), .cfg_cv(cfg_main), .allow(allow), .grant(grant));

   initiation_gate #(.N_LAT(8), .CV_SRC(CV_FROM_PORT)) u_initiation_gate_cfg (
      .clk(clk), .rst(rst), .req(req2), .cfg_cv(cfg2), .allow(allow2), .grant(grant2));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic r2);
      @(negedge clk);
      req  = r;
      req2 = r2;
      #1;
      m_allow = 1'b1;
      for (int s = 0; s < 4; s++) if ((busy[s] & RT[s]) != 9'd0) m_allow = 1'b0;
   endtask

   task automatic commit();
      if (grant === 1'b1) begin
         chk("R3 stage double booking", {31'd0, !m_allow}, 32'd0);
         for (int s = 0; s < 4; s++) busy[s] = busy[s] | RT[s];
      end
      for (int s = 0; s < 4; s++) busy[s] = busy[s] >> 1;
   endtask

   task automatic clear_model();
      for (int s = 0; s < 4; s++) busy[s] = 9'd0;
   endtask

   initial begin
      string tg;
      clear_model();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: open after reset, no grant without request
      step(1'b0, 1'b0);
      chk("R1 allow after reset", {31'd0, allow}, 32'd1);
      chk("R2 no grant without req", {31'd0, grant}, 32'd0);
      commit();

      for (int i = 0; i < 36; i++) begin
         if (i < 12) tg = "R5 reference greedy cycle";
         else if (i == 24) tg = "R6 long gap reload";
         else if (!VEC[i][1]) tg = "R2 idle";
         else tg = "R4 greedy issue";
         step(VEC[i][1], 1'b0);
         chk(tg, {31'd0, grant}, {31'd0, VEC[i][0]});
         chk("R3 allow vs reservation model", {31'd0, allow}, {31'd0, m_allow});
         commit();
      end

      // R7: port ignored in parameter variant (all-ones would delay the grant to c44)
      for (int i = 36; i <= 42; i++) begin
         step(1'b1, 1'b0);
         chk("R7 cfg ignored, grant vs model", {31'd0, grant}, {31'd0, m_allow});
         if (i == 42) chk("R7 cfg ignored, latency 7 grant", {31'd0, grant}, 32'd1);
         commit();
      end

      // R1: reset with tasks in flight
      @(negedge clk);
      req = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      clear_model();
      step(1'b1, 1'b0);
      chk("R1 grant right after reset", {31'd0, grant}, 32'd1);
      commit();
      step(1'b1, 1'b0);
      chk("R1 latency 1 refused after reset", {31'd0, grant}, 32'd0);
      commit();
      step(1'b0, 1'b0);
      commit();

      // R7: port variant, forbidden {1,3}
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1);
         chk("R7 port vector 05", {31'd0, grant2}, {31'd0, (i % 2 == 0)});
         commit();
      end
      cfg2 = 8'h02;
      for (int i = 0; i < 10; i++) begin
         step(1'b0, 1'b0);
         chk("R2 port variant idle", {31'd0, grant2}, 32'd0);
         commit();
      end
      // R7: forbidden {2}, expected 1,1,0,0,1
      for (int i = 0; i < 5; i++) begin
         step(1'b0, 1'b1);
         chk("R7 port vector 02", {31'd0, grant2}, {31'd0, (i == 0 || i == 1 || i == 4)});
         commit();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog act=running exp=done");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule